// File: doc/BRIEF.md
# UART Receive Queue with Character-Timeout Ageing

This block is the buffering stage on the receive side of a UART. A deserializer hands it one character at a time, with optional break and framing-error qualifiers. The block stores each character in a first-in first-out queue together with its error tags. A register-read strobe removes the oldest entry. The popped word appears on a registered output with a valid bit attached.

Alongside the queue the block keeps several status flags. The receive-ready flag is driven by a programmable trigger level. The data-ready and empty flags track occupancy. Three sticky bits record a dropped character, a received break and an ageing timeout. The ageing timer catches characters that sit below the trigger level for too long: it counts clock cycles whenever the queue holds data that has not yet reached the trigger level. Any push or pop restarts the count. Interrupt combining, bit sampling and bus decoding belong to neighbouring blocks.

Top module: `uart_rxq_age`

## Requirements
- R1: Characters leave the queue in the order they were accepted, and up to DEPTH entries are held at once.
- R2: A character offered while DEPTH entries are held is discarded, and the sticky overrun bit `ovr_sticky` is set.
- R3: The accepted character that makes the occupancy reach DEPTH is stored with its overrun tag (bit DATA_W+2) and its error tag (bit DATA_W+3) set. A character pushed with `push_ferr` is stored with its framing tag (bit DATA_W+1) and its error tag set.
- R4: After any push the block sets `rx_ready` if the new occupancy is at or above `trig_lvl`. Every push also sets `data_rdy` and clears `fifo_empty`.
- R5: A pop from a non-empty queue places the entry on `rd_word` one cycle later, with the valid bit (bit DATA_W+4) set. If the remaining occupancy is below `trig_lvl`, `rx_ready` is cleared. If it is zero, `data_rdy` is cleared and `fifo_empty` is set.
- R6: A pop from an empty queue returns an all-zero `rd_word` and leaves every flag unchanged.
- R7: The ageing timer runs only while `rx_ready` is clear and `fifo_empty` is clear. `age_sticky` is set AGE_CYCLES cycles after the most recent push, provided no pop occurs in between.
- R8: Every push and every pop restarts the ageing count from zero.
- R9: A push with `push_brk` stores an entry with a zero character and its break (bit DATA_W), framing (bit DATA_W+1) and error (bit DATA_W+3) tags set. It also sets the sticky break bit `brk_sticky`.
- R10: Pushes are ignored while `rx_en` is low.
- R11: `sticky_clr` clears sticky bits where it holds ones: bit 0 clears `ovr_sticky`, bit 1 clears `age_sticky` and bit 2 clears `brk_sticky`. A set in the same cycle wins over a clear.
- R12: A one-cycle `soft_clr` empties the queue, stops the timer, clears all sticky bits, `rx_ready`, `data_rdy` and `rd_word`, and sets `fifo_empty`.
- R13: After reset `fifo_empty` is 1, and every other flag and `rd_word` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous soft reset of queue, timer and flags |
| rx_en | input | 1 | Receiver enable; pushes are accepted only while high |
| trig_lvl | input | TRIG_W | Occupancy trigger level for `rx_ready` |
| push_vld | input | 1 | Deserializer presents a character this cycle |
| push_char | input | DATA_W | Received character |
| push_brk | input | 1 | The pushed item is a break condition |
| push_ferr | input | 1 | The pushed character had a framing error |
| rd_pop | input | 1 | Register read: pop the oldest entry |
| sticky_clr | input | 3 | Write-one-to-clear for overrun, ageing and break bits |
| rd_word | output | DATA_W+5 | Last popped word {valid, err, ovr, ferr, brk, char} |
| rx_ready | output | 1 | Occupancy reached the trigger level |
| data_rdy | output | 1 | At least one entry is held |
| fifo_empty | output | 1 | No entry is held |
| ovr_sticky | output | 1 | A character was dropped on a full queue |
| age_sticky | output | 1 | Ageing timeout occurred |
| brk_sticky | output | 1 | A break was received |

## Verification
The bench builds the block with DEPTH=8, AGE_CYCLES=20 and TRIG_W=4. A queue depth of 8 lets a handful of pushes reach the full and last-slot overrun cases. A 20-cycle timeout puts the exact expiry edge, and its shift after a mid-wait restart, within a short directed test. A 4-bit trigger lets the trigger level be set at the full depth, so `rx_ready` rises only on the final slot.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

   // Error qualifiers stored above the character in every entry
   typedef struct packed {
      logic err;
      logic ovr;
      logic ferr;
      logic brk;
   } rxq_tag_t;

   localparam int TAG_W = $bits(rxq_tag_t);

   // Sticky clear vector bit assignment
   localparam int CLR_OVR = 0;
   localparam int CLR_AGE = 1;
   localparam int CLR_BRK = 2;

endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
   parameter int DEPTH = 32,
   parameter int W     = 12,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [W-1:0]     wr_data,
   input  logic             rd_en,
   output logic [W-1:0]     head,
   output logic [CNT_W-1:0] count
);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [PTR_W-1:0] wr_ptr_inc, rd_ptr_inc;

   // Pointer advance: free wrap for powers of two, explicit compare otherwise
   if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign wr_ptr_inc = wr_ptr + 1'b1;
      assign rd_ptr_inc = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_ptr_inc = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_ptr_inc = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr_inc;
         if (rd_en) rd_ptr <= rd_ptr_inc;
         count <= count + CNT_W'(wr_en) - CNT_W'(rd_en);
      end
   end

   assign head = mem[rd_ptr];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)); // R1

   AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(DEPTH)) |-> !wr_en); // R2

endmodule

// File: rtl/uart_rxq_age_timer.sv
module uart_rxq_age_timer #(
   parameter int AGE_CYCLES = 700,
   localparam int CW = $clog2(AGE_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic restart,
   output logic expire
);

   logic [CW-1:0] cnt;
   logic          fired;
   logic          at_end;

   assign at_end = (cnt == CW'(AGE_CYCLES - 1));
   assign expire = run && !restart && !clr && !fired && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         fired <= 1'b0;
      end else if (clr || restart || !run) begin
         cnt   <= '0;
         fired <= 1'b0;
      end else if (!fired) begin
         if (at_end) begin
            fired <= 1'b1;
            cnt   <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_NO_EXPIRE_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !expire); // R8

endmodule

// File: rtl/uart_rxq_age.sv
module uart_rxq_age
   import uart_rxq_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int DEPTH      = 32,
   parameter int TRIG_W     = 6,
   parameter int AGE_CYCLES = 700,
   localparam int ENT_W = DATA_W + TAG_W,
   localparam int OUT_W = ENT_W + 1,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int CMP_W = ((TRIG_W > CNT_W) ? TRIG_W : CNT_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_clr,
   input  logic              rx_en,
   input  logic [TRIG_W-1:0] trig_lvl,
   input  logic              push_vld,
   input  logic [DATA_W-1:0] push_char,
   input  logic              push_brk,
   input  logic              push_ferr,
   input  logic              rd_pop,
   input  logic [2:0]        sticky_clr,
   output logic [OUT_W-1:0]  rd_word,
   output logic              rx_ready,
   output logic              data_rdy,
   output logic              fifo_empty,
   output logic              ovr_sticky,
   output logic              age_sticky,
   output logic              brk_sticky
);

   // Elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("uart_rxq_age: DEPTH must be at least 2");
   end
   if (AGE_CYCLES < 2) begin : g_bad_age
      $error("uart_rxq_age: AGE_CYCLES must be at least 2");
   end
   if ((1 << TRIG_W) <= DEPTH) begin : g_bad_trig
      $error("uart_rxq_age: TRIG_W too narrow to reach DEPTH");
   end

   logic [CNT_W-1:0] count, cnt_nxt;
   logic [ENT_W-1:0] head, entry;
   rxq_tag_t         tag;
   logic             push_evt, full, wr_ok, pop_ok, last_slot;
   logic             age_expire;
   logic [CMP_W-1:0] occ_x, trig_x;

   assign push_evt  = push_vld && rx_en && !soft_clr;
   assign full      = (count == CNT_W'(DEPTH));
   assign wr_ok     = push_evt && !full;
   assign pop_ok    = rd_pop && (count != '0) && !soft_clr;
   assign last_slot = (count == CNT_W'(DEPTH - 1));

   always_comb begin
      tag.brk  = push_brk;
      tag.ferr = push_brk || push_ferr;
      tag.ovr  = last_slot;
      tag.err  = push_brk || push_ferr || last_slot;
      entry    = {tag, (push_brk ? {DATA_W{1'b0}} : push_char)};
   end

   assign cnt_nxt = count + CNT_W'(wr_ok) - CNT_W'(pop_ok);
   assign occ_x   = CMP_W'(cnt_nxt);
   assign trig_x  = CMP_W'(trig_lvl);

   uart_rxq_store #(
      .DEPTH (DEPTH),
      .W     (ENT_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (soft_clr),
      .wr_en   (wr_ok),
      .wr_data (entry),
      .rd_en   (pop_ok),
      .head    (head),
      .count   (count)
   );

   uart_rxq_age_timer #(
      .AGE_CYCLES (AGE_CYCLES)
   ) u_age (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (soft_clr),
      .run     (!rx_ready && !fifo_empty),
      .restart (push_evt || pop_ok),
      .expire  (age_expire)
   );

   // Occupancy flags: updated only on push and pop events
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_ready   <= 1'b0;
         data_rdy   <= 1'b0;
         fifo_empty <= 1'b1;
      end else if (soft_clr) begin
         rx_ready   <= 1'b0;
         data_rdy   <= 1'b0;
         fifo_empty <= 1'b1;
      end else begin
         if (push_evt) begin
            data_rdy   <= 1'b1;
            fifo_empty <= 1'b0;
         end else if (pop_ok && cnt_nxt == '0) begin
            data_rdy   <= 1'b0;
            fifo_empty <= 1'b1;
         end
         if (push_evt && occ_x >= trig_x)
            rx_ready <= 1'b1;
         else if (pop_ok && occ_x < trig_x)
            rx_ready <= 1'b0;
      end
   end

   // Sticky status: set wins over write-one-to-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_sticky <= 1'b0;
         age_sticky <= 1'b0;
         brk_sticky <= 1'b0;
      end else if (soft_clr) begin
         ovr_sticky <= 1'b0;
         age_sticky <= 1'b0;
         brk_sticky <= 1'b0;
      end else begin
         if (push_evt && full)         ovr_sticky <= 1'b1;
         else if (sticky_clr[CLR_OVR]) ovr_sticky <= 1'b0;
         if (age_expire)               age_sticky <= 1'b1;
         else if (sticky_clr[CLR_AGE]) age_sticky <= 1'b0;
         if (push_evt && push_brk)     brk_sticky <= 1'b1;
         else if (sticky_clr[CLR_BRK]) brk_sticky <= 1'b0;
      end
   end

   // Read return register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_word <= '0;
      else if (soft_clr)
         rd_word <= '0;
      else if (rd_pop)
         rd_word <= pop_ok ? {1'b1, head} : '0;
   end

   AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
      (rd_pop && fifo_empty) |=> (rd_word == '0)); // R6

   AST_POP_VALID_BIT: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
      (rd_pop && !fifo_empty) |=> rd_word[OUT_W-1]); // R5

   AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
      (push_vld && rx_en && full && !rd_pop) |=> (ovr_sticky && count == CNT_W'(DEPTH))); // R2

   AST_RXEN_GATE: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
      (!rx_en && !rd_pop) |=> $stable(count)); // R10

   AST_AGE_ONLY_WAITING: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
      $rose(age_sticky) |-> $past(!rx_ready && !fifo_empty)); // R7

   AST_PUSH_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
      push_evt |=> (!fifo_empty && data_rdy)); // R4

endmodule

// File: tb/uart_rxq_age_bench.sv
module uart_rxq_age_bench;

   localparam int DATA_W = 8;
   localparam int DEPTH  = 8;
   localparam int TRIG_W = 4;
   localparam int AGE    = 20;
   localparam int OUT_W  = DATA_W + 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              soft_clr = 1'b0;
   logic              rx_en = 1'b1;
   logic [TRIG_W-1:0] trig_lvl = '0;
   logic              push_vld = 1'b0;
   logic [DATA_W-1:0] push_char = '0;
   logic              push_brk = 1'b0;
   logic              push_ferr = 1'b0;
   logic              rd_pop = 1'b0;
   logic [2:0]        sticky_clr = '0;
   logic [OUT_W-1:0]  rd_word;
   logic rx_ready, data_rdy, fifo_empty, ovr_sticky, age_sticky, brk_sticky;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   uart_rxq_age #(
      .DATA_W     (DATA_W),
      .DEPTH      (DEPTH),
      .TRIG_W     (TRIG_W),
      .AGE_CYCLES (AGE)
   ) u_uart_rxq_age (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_clr   (soft_clr),
      .rx_en      (rx_en),
      .trig_lvl   (trig_lvl),
      .push_vld   (push_vld),
      .push_char  (push_char),
      .push_brk   (push_brk),
      .push_ferr  (push_ferr),
      .rd_pop     (rd_pop),
      .sticky_clr (sticky_clr),
      .rd_word    (rd_word),
      .rx_ready   (rx_ready),
      .data_rdy   (data_rdy),
      .fifo_empty (fifo_empty),
      .ovr_sticky (ovr_sticky),
      .age_sticky (age_sticky),
      .brk_sticky (brk_sticky)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] c, input logic brk, input logic ferr);
      push_vld = 1'b1; push_char = c; push_brk = brk; push_ferr = ferr;
      @(negedge clk);
      push_vld = 1'b0; push_brk = 1'b0; push_ferr = 1'b0;
   endtask

   task automatic pop(output logic [OUT_W-1:0] w);
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
      w = rd_word;
   endtask

   task automatic clear_all();
      soft_clr = 1'b1;
      @(negedge clk);
      soft_clr = 1'b0;
      rx_en = 1'b1;
   endtask

   function automatic logic [OUT_W-1:0] word(input logic [3:0] tags, input logic [7:0] c);
      return {1'b1, tags, c};
   endfunction

   task automatic t_reset();
      chk("R13", "empty", fifo_empty, 1);
      chk("R13", "ready", rx_ready, 0);
      chk("R13", "data_rdy", data_rdy, 0);
      chk("R13", "stickies", {ovr_sticky, age_sticky, brk_sticky}, 0);
      chk("R13", "rd_word", rd_word, 0);
   endtask

   task automatic t_order_trigger();
      logic [OUT_W-1:0] w;
      clear_all();
      trig_lvl = 2;
      push(8'h41, 0, 0);
      chk("R4", "ready below trig", rx_ready, 0);
      chk("R4", "data_rdy", data_rdy, 1);
      chk("R4", "empty cleared", fifo_empty, 0);
      push(8'h42, 0, 0);
      chk("R4", "ready at trig", rx_ready, 1);
      push(8'h43, 0, 0);
      pop(w);
      chk("R1", "first out", w, word(4'h0, 8'h41));
      chk("R5", "ready kept at 2", rx_ready, 1);
      pop(w);
      chk("R1", "second out", w, word(4'h0, 8'h42));
      chk("R5", "ready cleared below", rx_ready, 0);
      chk("R5", "data_rdy kept", data_rdy, 1);
      pop(w);
      chk("R1", "third out", w, word(4'h0, 8'h43));
      chk("R5", "empty set", fifo_empty, 1);
      chk("R5", "data_rdy cleared", data_rdy, 0);
   endtask

   task automatic t_full_overrun();
      logic [OUT_W-1:0] w;
      clear_all();
      trig_lvl = DEPTH;
      for (int i = 0; i < DEPTH - 1; i++) push(8'h10 + 8'(i), 0, 0);
      chk("R4", "ready below full", rx_ready, 0);
      push(8'h1F, 0, 0);
      chk("R4", "ready at full", rx_ready, 1);
      chk("R2", "no ovr yet", ovr_sticky, 0);
      push(8'h77, 0, 0);
      chk("R2", "ovr sticky", ovr_sticky, 1);
      for (int i = 0; i < DEPTH - 1; i++) begin
         pop(w);
         chk("R1", "fill order", w, word(4'h0, 8'h10 + 8'(i)));
         if (i == 0) chk("R5", "ready drop after pop", rx_ready, 0);
      end
      pop(w);
      chk("R3", "last slot tagged", w, word(4'b1100, 8'h1F));
      chk("R2", "dropped char absent", fifo_empty, 1);
      pop(w);
      chk("R6", "empty read zero", w, 0);
      chk("R6", "flags unchanged", {rx_ready, data_rdy, fifo_empty, ovr_sticky}, 4'b0011);
   endtask

   task automatic t_break_ferr();
      logic [OUT_W-1:0] w;
      clear_all();
      trig_lvl = 1;
      push(8'h5A, 1, 0);
      chk("R9", "brk sticky", brk_sticky, 1);
      push(8'h33, 0, 1);
      pop(w);
      chk("R9", "break entry", w, word(4'b1011, 8'h00));
      pop(w);
      chk("R3", "ferr entry", w, word(4'b1010, 8'h33));
   endtask

   task automatic t_rxen();
      logic [OUT_W-1:0] w;
      clear_all();
      rx_en = 1'b0;
      push(8'h99, 0, 0);
      chk("R10", "still empty", fifo_empty, 1);
      chk("R10", "no data_rdy", data_rdy, 0);
      pop(w);
      chk("R10", "nothing stored", w, 0);
      rx_en = 1'b1;
   endtask

   task automatic t_age();
      clear_all();
      trig_lvl = 4;
      push(8'h01, 0, 0);
      repeat (AGE - 1) @(negedge clk);
      chk("R7", "not yet expired", age_sticky, 0);
      @(negedge clk);
      chk("R7", "expired", age_sticky, 1);
      // restart case
      clear_all();
      trig_lvl = 4;
      push(8'h02, 0, 0);
      repeat (10) @(negedge clk);
      push(8'h03, 0, 0);
      repeat (AGE - 1) @(negedge clk);
      chk("R8", "restart delays expiry", age_sticky, 0);
      @(negedge clk);
      chk("R8", "expiry after restart", age_sticky, 1);
      // no run while ready is set
      clear_all();
      trig_lvl = 1;
      push(8'h04, 0, 0);
      repeat (AGE + 5) @(negedge clk);
      chk("R7", "idle while ready", age_sticky, 0);
   endtask

   task automatic t_sticky_clr();
      clear_all();
      trig_lvl = 4;
      push(8'h00, 1, 0);
      repeat (AGE + 2) @(negedge clk);
      chk("R11", "age and brk set", {age_sticky, brk_sticky}, 2'b11);
      sticky_clr = 3'b010;
      @(negedge clk);
      sticky_clr = 3'b000;
      chk("R11", "age cleared only", {age_sticky, brk_sticky}, 2'b01);
      sticky_clr = 3'b100;
      @(negedge clk);
      sticky_clr = 3'b000;
      chk("R11", "brk cleared", brk_sticky, 0);
   endtask

   task automatic t_soft_clr();
      logic [OUT_W-1:0] w;
      clear_all();
      trig_lvl = 1;
      for (int i = 0; i < DEPTH + 1; i++) push(8'hA0, 0, 0);
      chk("R12", "pre state", {rx_ready, ovr_sticky}, 2'b11);
      clear_all();
      chk("R12", "flags idle", {rx_ready, data_rdy, fifo_empty, ovr_sticky, age_sticky, brk_sticky}, 6'b001000);
      pop(w);
      chk("R12", "queue emptied", w, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_order_trigger();
      t_full_overrun();
      t_break_ferr();
      t_rxen();
      t_age();
      t_sticky_clr();
      t_soft_clr();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule